// File: doc/BRIEF.md
# Signed Divide-by-Constant Unit

This block divides a two's-complement W-bit dividend by a signed divisor that is fixed when the design is elaborated. It returns both a quotient and a remainder. The quotient truncates toward zero, and a nonzero remainder carries the sign of the dividend. No divider array is built. The quotient comes from a signed multiply by a reciprocal ("magic") constant that a package function derives from W and the divisor. Only the upper half of the double-width product is kept. Then come a sign-dependent add or subtract of the dividend, an arithmetic right shift, and a final increment by the sign bit of the shifted value. The remainder is the dividend minus the quotient times the divisor.

Divisors 0, 1 and -1 are resolved at elaboration into trivial logic instead of the reciprocal path. A caller presents a dividend with a valid strobe. Both results appear registered on the following clock, together with an output valid.

Top module: `sdiv_const`

## Requirements
- R1: For a divisor with magnitude two or more, every W-bit signed dividend gives the quotient truncated toward zero, e.g. W=8: -7/3 = -2, 127/-3 = -42, -128/7 = -18.
- R2: For a divisor with magnitude two or more, the remainder equals dividend minus quotient times divisor, modulo 2^W. A nonzero remainder has the dividend's sign, and its magnitude is below the divisor's magnitude.
- R3: With divisor 1, the quotient equals the dividend and the remainder is zero.
- R4: With divisor -1, the quotient is zero minus the dividend, modulo 2^W. The most negative value maps to itself (W=8: -128 gives -128) and no overflow indication exists. The remainder is zero.
- R5: With divisor 0, quotient and remainder are both zero for every dividend.
- R6: out_valid is high in exactly the clock cycle that follows a rising clock edge at which in_valid was high. It is low otherwise.
- R7: At an edge where in_valid is low, out_quot and out_rem keep their previous values whatever in_dividend holds.
- R8: While rst_n is low, out_valid, out_quot and out_rem are all zero, regardless of in_valid and in_dividend.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| in_valid | input | 1 | Dividend qualifier; results are captured when high |
| in_dividend | input | W | Two's-complement dividend |
| out_valid | output | 1 | High one cycle after an accepted dividend |
| out_quot | output | W | Registered quotient, truncated toward zero |
| out_rem | output | W | Registered remainder, sign of the dividend |

## Verification
The assertions assume that in_valid and in_dividend are known, two-valued levels at every rising edge once the internal reset has released. Before that point they are disabled. The remainder-magnitude property takes for granted that the divisor magnitude is at least two, so it is placed only in the reciprocal branch. The stimulus changes inputs only on falling edges and holds in_valid low across reset release. It sweeps every 8-bit signed dividend, including the most negative value, through six instances whose divisors are 3, -3, 7, -1, 1 and 0.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

  typedef enum logic [1:0] {
    ADJ_NONE = 2'd0,
    ADJ_ADD  = 2'd1,
    ADJ_SUB  = 2'd2
  } adj_e;

  typedef struct packed {
    logic [63:0] magic;
    logic [7:0]  shift;
  } magic_t;

  // Reciprocal constant and post-shift for signed division by d at width w.
  // Divisors 0, 1 and -1 return zeros; they never use the reciprocal path.
  function automatic magic_t magic_of(input int w, input int d);
    longint unsigned half, ad, t, anc, q1, r1, q2, r2, delta, mask, m;
    int  p;
    bit  done;
    magic_t res;
    res = '0;
    if (d == 0 || d == 1 || d == -1) return res;
    mask = (64'd1 << w) - 64'd1;
    half = 64'd1 << (w - 1);
    ad   = (d < 0) ? longint'(-d) : longint'(d);
    t    = half + ((d < 0) ? 64'd1 : 64'd0);
    anc  = t - 64'd1 - (t % ad);
    p    = w - 1;
    q1   = half / anc;
    r1   = half - q1 * anc;
    q2   = half / ad;
    r2   = half - q2 * ad;
    done = 1'b0;
    for (int i = 0; i < 2 * w + 2; i++) begin
      if (!done) begin
        p  = p + 1;
        q1 = (q1 << 1) & mask;
        r1 = r1 << 1;
        if (r1 >= anc) begin
          q1 = (q1 + 64'd1) & mask;
          r1 = r1 - anc;
        end
        q2 = (q2 << 1) & mask;
        r2 = r2 << 1;
        if (r2 >= ad) begin
          q2 = (q2 + 64'd1) & mask;
          r2 = r2 - ad;
        end
        delta = ad - r2;
        if (!(q1 < delta || (q1 == delta && r1 == 64'd0))) done = 1'b1;
      end
    end
    m = (q2 + 64'd1) & mask;
    if (d < 0) m = (~m + 64'd1) & mask;
    res.magic = m;
    res.shift = 8'(p - w);
    return res;
  endfunction

endpackage

// File: rtl/sdiv_rst_sync.sv
module sdiv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/sdiv_mulhi.sv
module sdiv_mulhi
  import sdiv_pkg::*;
#(
  parameter int               W     = 8,
  parameter logic [W-1:0]     MAGIC = '0,
  parameter adj_e             ADJ   = ADJ_NONE
) (
  input  logic [W-1:0] dividend,
  output logic [W-1:0] hi_adj
);
  localparam int PW = 2 * W;

  logic signed [PW-1:0] x_ext;
  logic signed [PW-1:0] m_ext;
  logic signed [PW-1:0] prod;
  logic        [W-1:0]  hi;

  always_comb begin
    x_ext = signed'({{W{dividend[W-1]}}, dividend});
    m_ext = signed'({{W{MAGIC[W-1]}}, MAGIC});
    prod  = x_ext * m_ext;
    hi    = W'(prod >> W);
  end

  // Sign fix-up of the high product, picked at elaboration.
  if (ADJ == ADJ_ADD) begin : g_add
    assign hi_adj = hi + dividend;
  end else if (ADJ == ADJ_SUB) begin : g_sub
    assign hi_adj = hi - dividend;
  end else begin : g_none
    assign hi_adj = hi;
  end
endmodule

// File: rtl/sdiv_round.sv
module sdiv_round #(
  parameter int W     = 8,
  parameter int SHIFT = 0
) (
  input  logic [W-1:0] hi_adj,
  output logic [W-1:0] quot
);
  logic signed [W-1:0] shifted;

  always_comb begin
    shifted = $signed(hi_adj) >>> SHIFT;
    // A negative estimate is one below the truncated result: add its sign bit.
    quot    = shifted + {{(W-1){1'b0}}, shifted[W-1]};
  end
endmodule

// File: rtl/sdiv_rem.sv
module sdiv_rem #(
  parameter int           W     = 8,
  parameter logic [W-1:0] DIV_W = '0
) (
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] quot,
  output logic [W-1:0] rem
);
  logic [W-1:0] back;

  always_comb begin
    back = quot * DIV_W;
    rem  = dividend - back;
  end
endmodule

// File: rtl/sdiv_const.sv
module sdiv_const
  import sdiv_pkg::*;
#(
  parameter int W   = 8,
  parameter int DIV = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_dividend,
  output logic         out_valid,
  output logic [W-1:0] out_quot,
  output logic [W-1:0] out_rem
);
  localparam magic_t       INFO      = magic_of(W, DIV);
  localparam logic [W-1:0] MAGIC     = INFO.magic[W-1:0];
  localparam int           SHIFT     = int'(INFO.shift);
  localparam bit           MAGIC_NEG = MAGIC[W-1];
  localparam adj_e         ADJ       = (DIV > 0 && MAGIC_NEG)  ? ADJ_ADD :
                                       (DIV < 0 && !MAGIC_NEG) ? ADJ_SUB : ADJ_NONE;
  localparam logic [W-1:0] DIV_W     = W'(DIV);
  localparam int           DIV_MAG   = (DIV < 0) ? -DIV : DIV;

  logic         rst_s;
  logic [W-1:0] quot_c;
  logic [W-1:0] rem_c;
  logic         vld_d;
  logic [W-1:0] quot_d;
  logic [W-1:0] rem_d;

  sdiv_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_s)
  );

  if (DIV == 0) begin : g_zero
    assign quot_c = '0;
    assign rem_c  = '0;
    a_r5_zero_out: assert property (@(posedge clk) disable iff (!rst_s)
      out_quot == '0 && out_rem == '0);
  end else if (DIV == 1) begin : g_one
    assign quot_c = in_dividend;
    assign rem_c  = '0;
    a_r3_pass: assert property (@(posedge clk) disable iff (!rst_s)
      in_valid |=> out_quot == $past(in_dividend) && out_rem == '0);
  end else if (DIV == -1) begin : g_neg
    assign quot_c = '0 - in_dividend;
    assign rem_c  = '0;
    a_r4_negate: assert property (@(posedge clk) disable iff (!rst_s)
      in_valid |=> out_quot + $past(in_dividend) == '0 && out_rem == '0);
  end else begin : g_recip
    logic [W-1:0] hi_adj;
    int           rem_i;
    int           rem_mag;

    sdiv_mulhi #(.W(W), .MAGIC(MAGIC), .ADJ(ADJ)) u_mulhi (
      .dividend (in_dividend),
      .hi_adj   (hi_adj)
    );

    sdiv_round #(.W(W), .SHIFT(SHIFT)) u_round (
      .hi_adj (hi_adj),
      .quot   (quot_c)
    );

    sdiv_rem #(.W(W), .DIV_W(DIV_W)) u_rem (
      .dividend (in_dividend),
      .quot     (quot_c),
      .rem      (rem_c)
    );

    always_comb begin
      rem_i   = int'($signed(rem_c));
      rem_mag = (rem_i < 0) ? -rem_i : rem_i;
    end

    a_r2_rem_bound: assert property (@(posedge clk) disable iff (!rst_s)
      in_valid |-> rem_mag < DIV_MAG);
    a_r2_rem_sign: assert property (@(posedge clk) disable iff (!rst_s)
      (in_valid && rem_c != '0) |-> rem_c[W-1] == in_dividend[W-1]);
  end

  // Next-state: data registers load only on an accepted dividend.
  always_comb begin
    vld_d  = in_valid;
    quot_d = out_quot;
    rem_d  = out_rem;
    if (in_valid) begin
      quot_d = quot_c;
      rem_d  = rem_c;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      out_valid <= 1'b0;
      out_quot  <= '0;
      out_rem   <= '0;
    end else begin
      out_valid <= vld_d;
      out_quot  <= quot_d;
      out_rem   <= rem_d;
    end
  end

  a_r6_valid_next: assert property (@(posedge clk) disable iff (!rst_s)
    in_valid |=> out_valid);
  a_r6_idle_next: assert property (@(posedge clk) disable iff (!rst_s)
    !in_valid |=> !out_valid);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_s)
    !in_valid |=> $stable(out_quot) && $stable(out_rem));
endmodule

// File: tb/tb_sdiv_const.sv
module tb_sdiv_const;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [W-1:0] in_dividend;

  logic         v3, vn3, v7, vm1, vp1, vz;
  logic [W-1:0] q3, qn3, q7, qm1, qp1, qz;
  logic [W-1:0] r3, rn3, r7, rm1, rp1, rz;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  sdiv_const #(.W(W), .DIV(3)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dividend(in_dividend),
    .out_valid(v3), .out_quot(q3), .out_rem(r3));
  sdiv_const #(.W(W), .DIV(-3)) dut_n3 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dividend(in_dividend),
    .out_valid(vn3), .out_quot(qn3), .out_rem(rn3));
  sdiv_const #(.W(W), .DIV(7)) dut_7 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dividend(in_dividend),
    .out_valid(v7), .out_quot(q7), .out_rem(r7));
  sdiv_const #(.W(W), .DIV(-1)) dut_m1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dividend(in_dividend),
    .out_valid(vm1), .out_quot(qm1), .out_rem(rm1));
  sdiv_const #(.W(W), .DIV(1)) dut_p1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dividend(in_dividend),
    .out_valid(vp1), .out_quot(qp1), .out_rem(rp1));
  sdiv_const #(.W(W), .DIV(0)) dut_z (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dividend(in_dividend),
    .out_valid(vz), .out_quot(qz), .out_rem(rz));

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, $signed(act), $signed(exp));
    end
  endtask

  // Present one dividend at the falling edge; return at the next falling edge.
  task automatic push(input int v);
    in_valid    = 1'b1;
    in_dividend = W'(v);
    @(negedge clk);
  endtask

  function automatic logic [W-1:0] ref_q(input int v, input int d);
    return (d == 0) ? '0 : W'(v / d);
  endfunction

  function automatic logic [W-1:0] ref_r(input int v, input int d);
    return (d == 0) ? '0 : W'(v % d);
  endfunction

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b1; in_dividend = 8'd77;
    repeat (3) @(negedge clk);
    chk("R8 valid in reset", {7'd0, v3}, 8'd0);
    chk("R8 quot in reset", q3, 8'd0);
    chk("R8 rem in reset", rn3, 8'd0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 quot after release", q7, 8'd0);
  endtask

  task automatic t_sweep_div3;
    for (int v = -128; v < 128; v++) begin
      push(v);
      chk("R1 div 3 quot", q3, ref_q(v, 3));
      chk("R2 div 3 rem", r3, ref_r(v, 3));
    end
  endtask

  task automatic t_sweep_divn3;
    for (int v = -128; v < 128; v++) begin
      push(v);
      chk("R1 div -3 quot", qn3, ref_q(v, -3));
      chk("R2 div -3 rem", rn3, ref_r(v, -3));
    end
  endtask

  task automatic t_sweep_div7;
    for (int v = -128; v < 128; v++) begin
      push(v);
      chk("R1 div 7 quot", q7, ref_q(v, 7));
      chk("R2 div 7 rem", r7, ref_r(v, 7));
    end
  endtask

  task automatic t_sweep_divm1;
    for (int v = -128; v < 128; v++) begin
      push(v);
      chk("R4 div -1 quot", qm1, ref_q(v, -1));
      chk("R4 div -1 rem", rm1, 8'd0);
    end
    push(-128);
    chk("R4 min wraps", qm1, 8'h80);
  endtask

  task automatic t_unit_and_zero;
    for (int v = -128; v < 128; v++) begin
      push(v);
      chk("R3 div 1 quot", qp1, W'(v));
      chk("R3 div 1 rem", rp1, 8'd0);
      chk("R5 div 0 quot", qz, 8'd0);
      chk("R5 div 0 rem", rz, 8'd0);
    end
  endtask

  task automatic t_hold;
    push(100);
    chk("R6 valid after accept", {7'd0, v3}, 8'd1);
    chk("R1 100/3", q3, 8'd33);
    in_valid    = 1'b0;
    in_dividend = 8'hCE;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R6 valid low when idle", {7'd0, v3}, 8'd0);
      chk("R7 quot held", q3, 8'd33);
      chk("R7 rem held", r3, 8'd1);
      chk("R7 rem held div -3", rn3, 8'd1);
    end
    push(-7);
    chk("R1 -7/3", q3, 8'hFE);
    chk("R2 -7 rem 3", r3, 8'hFF);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R6 single pulse", {7'd0, v7}, 8'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    in_valid    = 1'b0;
    in_dividend = '0;
    rst_n       = 1'b0;
    @(negedge clk);
    t_reset;
    t_sweep_div3;
    t_sweep_divn3;
    t_sweep_div7;
    t_sweep_divm1;
    t_unit_and_zero;
    t_hold;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule